// File: doc/BRIEF.md
# Tone and Divider Pin Output Selector

This block sits between the general-purpose output latches of one port and three of its pins: lane 0 is pin 0, lane 1 is pin 1 and lane 2 is pin 3. Each lane normally drives its latch bit whenever its direction bit selects output. Two option bits can replace these values. The tone option turns pins 0 and 1 into a complementary pair that follows an external tone source. The divider option turns pin 3 into a square wave at half the rate of a timer overflow pulse.

In both alternate modes, a single latch bit acts as the on/off switch. The pin 0 latch gates the tone pair, and the pin 3 latch gates the divider. A lane whose direction bit selects input is never driven, whatever the options are. The tone source and the overflow pulse come in as primary inputs. The only state in the block is the divider flip-flop.

Top module: `tone_pin_mux`

## Requirements
- R1: With its option clear, an output lane (`dir_in` bit = 0) has `pin_oe` = 1 and drives its own `lat` bit on `pin_drv`. Lane 0 and lane 1 use `opt_tone`. Lane 2 uses `opt_div`.
- R2: A lane whose `dir_in` bit is 1 (input) has `pin_oe` = 0 and `pin_drv` = 0, for any option setting.
- R3: With `opt_tone` = 1, lane 0 as output and `lat[0]` = 1, `pin_drv[0]` equals `tone_src[0]` in the same cycle.
- R4: With `opt_tone` = 1, lane 1 as output and `lat[0]` = 1, `pin_drv[1]` equals the complement of `tone_src[0]`. `lat[1]` has no effect in this mode.
- R5: With `opt_tone` = 1 and `lat[0]` = 0, lanes 0 and 1 drive 0 when they are outputs.
- R6: With `opt_div` = 1, lane 2 as output and `lat[2]` = 1, `pin_drv[2]` equals the divider state.
- R7: The divider state is 0 after reset. It inverts on each clock edge that sees `tmr_ovf` = 1 while `opt_div` = 1 and `lat[2]` = 1. Otherwise it holds.
- R8: With `opt_div` = 1 and `lat[2]` = 0, lane 2 drives 0 when it is an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opt_tone | input | 1 | Selects the tone pair on lanes 0 and 1 |
| opt_div | input | 1 | Selects the divider on lane 2 |
| dir_in | input | 3 | Per-lane direction, 1 = input |
| lat | input | 3 | Per-lane output latch bits |
| tone_src | input | 1 | Tone source signal |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle wide |
| pin_drv | output | 3 | Per-lane drive value |
| pin_oe | output | 3 | Per-lane output enable |

## Verification
An overflow pulse can arrive in the same cycle that the tone source flips or that the pin 3 latch changes. The bench provokes this both with random stimulus and with directed cases. In those cases the overflow pulse coincides with `lat[2]` falling, with `opt_div` turning on, and with a tone source edge. A bench model of the divider predicts whether the edge toggles the state or holds it. Every lane is then compared one cycle later, so a toggle that is lost or spurious shows up on pin 3 while the tone pair is checked alongside it.

// File: rtl/tone_pin_mux.sv
module tone_pin_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opt_tone,
  input  logic       opt_div,
  input  logic [2:0] dir_in,
  input  logic [2:0] lat,
  input  logic       tone_src,
  input  logic       tmr_ovf,
  output logic [2:0] pin_drv,
  output logic [2:0] pin_oe
);

  logic div_q;
  logic div_step;
  logic v0, v1, v3;

  assign div_step = opt_div & lat[2] & tmr_ovf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        div_q <= 1'b0;
    else if (div_step) div_q <= ~div_q;

  assign v0 = opt_tone ? (lat[0] &  tone_src) : lat[0];
  assign v1 = opt_tone ? (lat[0] & ~tone_src) : lat[1];
  assign v3 = opt_div  ? (lat[2] &  div_q)    : lat[2];

  assign pin_oe  = ~dir_in;
  assign pin_drv = {v3, v1, v0} & pin_oe;

  a_r2_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & dir_in) == 3'b000) && ((pin_drv & dir_in) == 3'b000));

  a_r4_pair_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_tone && lat[0] && dir_in[1:0] == 2'b00) |-> (pin_drv[0] != pin_drv[1]));

  a_r5_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_tone && !lat[0]) |-> (pin_drv[1:0] == 2'b00));

  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_div && lat[2] && tmr_ovf) |=> (div_q != $past(div_q)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(opt_div && lat[2] && tmr_ovf) |=> $stable(div_q));

  a_r8_div_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_div && !lat[2]) |-> !pin_drv[2]);

endmodule

// File: tb/tb_tone_pin_mux.sv
module tb_tone_pin_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opt_tone = 1'b0, opt_div = 1'b0, tone_src = 1'b0, tmr_ovf = 1'b0;
  logic [2:0] dir_in = 3'b111, lat = 3'b000;
  logic [2:0] pin_drv, pin_oe;
  int total = 0, bad = 0;
  logic m_div = 1'b0;

  always #5 clk = ~clk;

  tone_pin_mux dut (.clk(clk), .rst_n(rst_n), .opt_tone(opt_tone), .opt_div(opt_div),
    .dir_in(dir_in), .lat(lat), .tone_src(tone_src), .tmr_ovf(tmr_ovf),
    .pin_drv(pin_drv), .pin_oe(pin_oe));

  function automatic logic exp_drv(int k);
    if (dir_in[k]) return 1'b0;
    case (k)
      0: return opt_tone ? (lat[0] & tone_src) : lat[0];
      1: return opt_tone ? (lat[0] & ~tone_src) : lat[1];
      default: return opt_div ? (lat[2] & m_div) : lat[2];
    endcase
  endfunction

  function automatic string tag(int k);
    if (dir_in[k]) return "R2";
    if (k == 2) return !opt_div ? "R1" : (lat[2] ? "R6 R7" : "R8");
    if (!opt_tone) return "R1";
    if (!lat[0]) return "R5";
    return (k == 0) ? "R3" : "R4";
  endfunction

  task automatic check_all();
    for (int k = 0; k < 3; k++) begin
      total++;
      if (pin_drv[k] !== exp_drv(k)) begin
        bad++;
        $display("FAIL %s lane %0d drv actual=%b expected=%b", tag(k), k, pin_drv[k], exp_drv(k));
      end
      total++;
      if (pin_oe[k] !== ~dir_in[k]) begin
        bad++;
        $display("FAIL %s lane %0d oe actual=%b expected=%b", dir_in[k] ? "R2" : "R1", k, pin_oe[k], ~dir_in[k]);
      end
    end
  endtask

  task automatic step(logic ot, logic od, logic [2:0] d, logic [2:0] l, logic ts, logic ov);
    @(negedge clk);
    opt_tone = ot; opt_div = od; dir_in = d; lat = l; tone_src = ts; tmr_ovf = ov;
    #1;
    check_all();
    if (od && l[2] && ov) m_div = ~m_div;
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    #12;
    check_all();                         // R2 reset state, all inputs
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b1, 3'b000, 3'b100, 1'b0, 1'b0);  // R7 divider starts at 0
    step(1'b0, 1'b1, 3'b000, 3'b100, 1'b0, 1'b1);  // R6 R7 toggle
    step(1'b0, 1'b1, 3'b000, 3'b100, 1'b1, 1'b0);  // R6 divider high
    step(1'b0, 1'b1, 3'b000, 3'b000, 1'b0, 1'b1);  // R8 overflow with gate low: hold
    step(1'b0, 1'b1, 3'b000, 3'b100, 1'b0, 1'b0);  // R7 value held at 1
    step(1'b1, 1'b1, 3'b000, 3'b111, 1'b1, 1'b1);  // R3 R4 tone edge with overflow
    step(1'b1, 1'b1, 3'b000, 3'b101, 1'b0, 1'b1);  // R4 pin1 latch ignored
    step(1'b1, 1'b0, 3'b000, 3'b110, 1'b1, 1'b1);  // R5 gate low, overflow without option
    step(1'b1, 1'b1, 3'b111, 3'b111, 1'b1, 1'b1);  // R2 inputs ignore options
    step(1'b0, 1'b0, 3'b000, 3'b101, 1'b0, 1'b0);  // R1 plain outputs
    step(1'b0, 1'b0, 3'b000, 3'b010, 1'b1, 1'b1);  // R1 plain outputs
    for (int i = 0; i < 4000; i++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'($urandom),
           3'($urandom), 1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule